// File: doc/BRIEF.md
# Quadrature Window Phase Lock Detector

This block decides whether a bang-bang clock recovery loop is phase locked, and it reports how much of the incoming data jitter falls outside the expected transition window. Each time the recovery logic sees a data transition, it raises a strobe. With the strobe comes one bit: the quadrature clock as sampled at that transition. The quadrature clock is the in-phase clock delayed by a quarter of a unit interval, so the bit is one when the transition fell within ±0.25 UI of the ideal point.

The block keeps a running first-order low-pass average of these bits in unsigned fixed point, where the all-ones code stands for 1.0. The average starts at 0.5, which is the level that randomly placed transitions produce. It climbs toward 1.0 when the loop is locked and sinks when many transitions land outside the window. The average is exported as a graded excess-jitter level. It is also compared with a lock threshold of about 0.66 to form the lock flag. The filter coefficient is a power-of-two shift chosen by parameter, so the time constant, counted in transitions, can be set longer than one video line.

Top module: `qwin_lock_detect`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the level is set to half scale (0x8000 for a 16-bit level) and `phaseLock` is cleared.
- R2: At an edge where `edgeValid` and `quadSample` are both 1, the level L becomes L + ((0xFFFF − L) >> SHIFT), with the shift truncating.
- R3: At an edge where `edgeValid` is 1 and `quadSample` is 0, the level L becomes L − (L >> SHIFT).
- R4: At an edge where `edgeValid` is 0, the level keeps its value, whatever `quadSample` is.
- R5: `phaseLock` after an edge is 1 exactly when the level held before that edge was strictly greater than LOCK_LEVEL. The default LOCK_LEVEL is floor(0.66 × 2^16) = 43253.
- R6: The level never wraps. An in-window sample never lowers it and an out-of-window sample never raises it, so it stays within 0 to 0xFFFF under any run of samples.
- R7: A sustained run of in-window samples raises the level above the threshold and sets `phaseLock`. Alternating samples, or a low in-window density, leave `phaseLock` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edgeValid | input | 1 | A data transition was seen this cycle |
| quadSample | input | 1 | Quadrature clock sampled at that transition (1 means inside the window) |
| jitterLevel | output | 16 | Filtered in-window fraction, where 0xFFFF is 1.0 |
| phaseLock | output | 1 | Level is above the lock threshold |

## Verification
The assertions assume that `edgeValid` and `quadSample` are defined, 0 or 1, at every rising edge after reset. They treat `quadSample` as meaningful only when a strobe is present. They also assume that reset is held for at least one edge before the first strobe. The bench drives both inputs only at falling edges from a single process. It holds reset low from time zero, and it toggles `quadSample` freely during idle cycles, so the hold rule is tested against a sample input that is moving. It sweeps the in-window density from 0 to 100 percent on a short shift, so that the saturation ends and both crossings of the threshold are all reached.

// File: rtl/qwin_pkg.sv
package qwin_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic update;      // a transition is present this cycle
    logic towardFull;  // move the average toward 1.0 (else toward 0)
  } qwin_strobe_t;

endpackage

// File: rtl/qwin_ctrl.sv
module qwin_ctrl
  import qwin_pkg::*;
(
  input  logic         edgeValid,
  input  logic         quadSample,
  output qwin_strobe_t strobe
);

  always_comb begin
    strobe            = '0;
    strobe.update     = edgeValid;
    strobe.towardFull = edgeValid & quadSample;
  end

endmodule

// File: rtl/qwin_dp.sv
module qwin_dp
  import qwin_pkg::*;
#(
  parameter int AVG_W      = 16,
  parameter int SHIFT      = 10,
  parameter int LOCK_LEVEL = (66 * (2 ** 16)) / 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qwin_strobe_t     strobe,
  output logic [AVG_W-1:0] avgLevel,
  output logic             lockFlag
);

  localparam logic [AVG_W-1:0] FULL_VAL = '1;
  localparam logic [AVG_W-1:0] HALF_VAL = {1'b1, {(AVG_W-1){1'b0}}};
  localparam logic [AVG_W-1:0] LOCK_VAL = AVG_W'(LOCK_LEVEL);

  logic [AVG_W-1:0] avgQ;
  logic [AVG_W-1:0] avgD;
  logic [AVG_W-1:0] upStep;
  logic [AVG_W-1:0] downStep;
  logic             lockQ;

  // Step sizes: a fraction 2^-SHIFT of the distance to the target rail
  always_comb begin
    upStep   = (FULL_VAL - avgQ) >> SHIFT;
    downStep = avgQ >> SHIFT;
  end

  always_comb begin
    avgD = avgQ;
    if (strobe.update) begin
      if (strobe.towardFull) avgD = avgQ + upStep;
      else                   avgD = avgQ - downStep;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avgQ  <= HALF_VAL;
      lockQ <= 1'b0;
    end else begin
      avgQ  <= avgD;
      lockQ <= (avgQ > LOCK_VAL);
    end
  end

  assign avgLevel = avgQ;
  assign lockFlag = lockQ;

endmodule

// File: rtl/qwin_lock_detect.sv
module qwin_lock_detect
  import qwin_pkg::*;
#(
  parameter int AVG_W      = 16,
  parameter int SHIFT      = 10,
  parameter int LOCK_LEVEL = (66 * (2 ** 16)) / 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edgeValid,
  input  logic             quadSample,
  output logic [AVG_W-1:0] jitterLevel,
  output logic             phaseLock
);

  qwin_strobe_t strobe;

  qwin_ctrl u_ctrl (
    .edgeValid (edgeValid),
    .quadSample(quadSample),
    .strobe    (strobe)
  );

  qwin_dp #(
    .AVG_W     (AVG_W),
    .SHIFT     (SHIFT),
    .LOCK_LEVEL(LOCK_LEVEL)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .avgLevel(jitterLevel),
    .lockFlag(phaseLock)
  );

endmodule

// File: rtl/qwin_lock_detect_chk.sv
module qwin_lock_detect_chk #(
  parameter int AVG_W      = 16,
  parameter int LOCK_LEVEL = (66 * (2 ** 16)) / 100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             edgeValid,
  input logic             quadSample,
  input logic [AVG_W-1:0] jitterLevel,
  input logic             phaseLock
);

  localparam logic [AVG_W-1:0] HALF_VAL = {1'b1, {(AVG_W-1){1'b0}}};
  localparam logic [AVG_W-1:0] LOCK_VAL = AVG_W'(LOCK_LEVEL);

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (jitterLevel == HALF_VAL && !phaseLock));

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !edgeValid |=> $stable(jitterLevel));

  p_no_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeValid && quadSample) |=> (jitterLevel >= $past(jitterLevel)));

  p_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeValid && !quadSample) |=> (jitterLevel <= $past(jitterLevel)));

  p_lock_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phaseLock == ($past(jitterLevel) > LOCK_VAL)));

endmodule

bind qwin_lock_detect qwin_lock_detect_chk #(
  .AVG_W     (AVG_W),
  .LOCK_LEVEL(LOCK_LEVEL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .edgeValid  (edgeValid),
  .quadSample (quadSample),
  .jitterLevel(jitterLevel),
  .phaseLock  (phaseLock)
);

// File: tb/test_qwin_lock_detect.sv
module test_qwin_lock_detect;

  localparam int SH = 3;
  localparam int TH = (66 * 65536) / 100;  // 43253

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        edgeValid = 1'b0;
  logic        quadSample = 1'b0;
  logic [15:0] jitterLevel;
  logic        phaseLock;

  int  nRun  = 0;
  int  nFail = 0;
  bit  done  = 1'b0;
  logic [15:0] expAvg = 16'h8000;

  always #5 clk = ~clk;

  qwin_lock_detect #(.AVG_W(16), .SHIFT(SH), .LOCK_LEVEL(TH)) i_qwin_lock_detect (
    .clk(clk), .rst_n(rst_n), .edgeValid(edgeValid), .quadSample(quadSample),
    .jitterLevel(jitterLevel), .phaseLock(phaseLock)
  );

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock with given strobe/sample; called and returns at a falling edge
  task automatic step(input logic ev, input logic s);
    logic [15:0] prev;
    prev = expAvg;
    edgeValid  = ev;
    quadSample = s;
    @(posedge clk);
    @(negedge clk);
    if (ev) begin
      if (s) expAvg = prev + ((16'hFFFF - prev) >> SH);  // R2
      else   expAvg = prev - (prev >> SH);               // R3
      check(s ? "R2 rise" : "R3 fall", int'(jitterLevel), int'(expAvg));
      check("R6 direction", int'(s ? (jitterLevel >= prev) : (jitterLevel <= prev)), 1);
    end else begin
      check("R4 hold", int'(jitterLevel), int'(prev));
    end
    check("R5 lock", int'(phaseLock), int'(prev > 16'(TH)));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    edgeValid = 1'b1;
    quadSample = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 level", int'(jitterLevel), 32'h8000);
    check("R1 lock", int'(phaseLock), 0);
    rst_n = 1'b1;
    edgeValid = 1'b0;
    expAvg = 16'h8000;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // idle cycles with a moving sample input
    for (int i = 0; i < 12; i++) step(1'b0, i[0]);
    // sustained in-window run
    for (int i = 0; i < 60; i++) step(1'b1, 1'b1);
    check("R7 lock after run", int'(phaseLock), 1);
    check("R6 near full", int'(jitterLevel >= 16'hFFF0), 1);
    for (int i = 0; i < 20; i++) step(1'b0, ~i[0]);
    // alternating samples
    for (int i = 0; i < 80; i++) step(1'b1, i[0]);
    check("R7 alternating unlock", int'(phaseLock), 0);
    // sustained out-of-window run
    for (int i = 0; i < 100; i++) step(1'b1, 1'b0);
    check("R6 near zero", int'(jitterLevel <= 16'h0010), 1);
    // density sweep
    for (int pct = 0; pct <= 100; pct += 10) begin
      for (int i = 0; i < 64; i++)
        step(($urandom_range(2) != 0), ($urandom_range(99) < pct));
    end
    // low density leaves lock off
    for (int i = 0; i < 80; i++) step(1'b1, ($urandom_range(99) < 30));
    check("R7 low density unlock", int'(phaseLock), 0);
    // mid-run reset after lock
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1);
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule